// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel sample words. It receives a bit clock, a word-select line and a data line, and recovers one 24-bit left word and one 24-bit right word per frame. Samples are two's complement and sent MSB first, and within a frame the left channel always comes first. Four framing formats can be selected: right-justified, I2S, left-justified and a pulse-framed DSP format. A packed 16-clock half-frame variant is also available. A 2-bit length selector sets the word length in the right-justified format.

The serial lines are oversampled by the block's own clock. They pass through a synchronizer, and the block detects the active bit-clock edge there. A slot tracker counts bit positions from the start of each channel slot. A fixed window for each format then picks which positions are captured and where each bit lands in the 24-bit word. When the next frame's left slot begins, the finished left and right words are copied to the outputs together, and a single-cycle strobe is raised.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after it is released, both sample outputs read zero and the frame strobe is low until the first complete frame has been received.
- R2: The format code `fmt_sel` selects the format: 00 is right-justified, 01 is I2S, 10 is left-justified and 11 is DSP. In right-justified and left-justified formats the left channel is sent while the word-select line is high. In I2S it is sent while the line is low.
- R3: Position 0 of a slot is the first active bit-clock edge on which the new word-select level is seen. In right-justified format, capture starts at position 8 when `rj_len` is 00 (24 bits), at position 12 when it is 01 (20 bits) and at position 16 when it is 10 (16 bits). Code 11 behaves as 24 bits. These start positions do not depend on the frame length.
- R4: In left-justified format the MSB is taken at position 0. In I2S format it is taken at position 1.
- R5: In DSP format, data and word-select are sampled on the falling bit-clock edge. A slot starts on the first sample that reads low after a sample that read high. The first such slot after reset is left, and the slots then alternate between left and right.
- R6: In left-justified, I2S and DSP formats, a word longer than 24 bits is accepted, and its first 24 bits (MSB first) are the ones delivered.
- R7: A word shorter than 24 bits (20- or 16-bit right-justified, or a packed word) appears in the top bits of its output, and the unused low bits read zero. In left-justified format the line is expected to read low after the LSB.
- R8: With `pack_en` high in right-justified or left-justified format, each half-frame is 16 bit clocks long. It holds a 16-bit word whose MSB is at position 0, and word-select high marks the left channel. In I2S and DSP formats, `pack_en` has no effect.
- R9: `frame_vld` is a one-cycle pulse, raised once for each frame in which both a left slot and a right slot were received, at the start of the next left slot. Both sample outputs change only in the cycle in which `frame_vld` is high.
- R10: `frame_vld` and the new sample values appear exactly 3 `clk` cycles after the active bit-clock edge that opens the next left slot (two synchronizer stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Word-select / frame-sync line |
| sdata | input | 1 | Serial sample data, MSB first |
| fmt_sel | input | 2 | Format code (00 RJ, 01 I2S, 10 LJ, 11 DSP) |
| rj_len | input | 2 | Right-justified word length code (00 24, 01 20, 10 16, 11 24) |
| pack_en | input | 1 | Packed 16-clock half-frame in RJ/LJ formats |
| left_smp | output | 24 | Last complete left sample, left-aligned |
| right_smp | output | 24 | Last complete right sample, left-aligned |
| frame_vld | output | 1 | One-cycle strobe when both samples update |

## Verification
The only timed result is the frame strobe together with the two samples. It is due 3 `clk` cycles after the bench drives the bit-clock edge that opens the next left slot. The bench drives every bit-clock edge on a falling `clk` edge and then samples at the next four falling edges. It expects the strobe to be low at the first two, high with the expected words at the third, and low again at the fourth. Expected words are computed from the word sent and its length by shifting: a top slice for long words, and a left shift with zero fill for short ones. The number of strobes in each configuration is counted and compared with the number of frames sent.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;
endpackage

// File: rtl/sarx_edge_sync.sv
module sarx_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrclk,
  input  logic sdata,
  input  logic fall_sel,
  output logic evt,
  output logic lr_s,
  output logic dat_s
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] bclk_q, lr_q, dat_q;
  logic [TOP:0] bclk_n, lr_n, dat_n;
  logic         bclk_last_q, bclk_last_n;

  always_comb begin
    bclk_n      = {bclk_q[TOP-1:0], bclk};
    lr_n        = {lr_q[TOP-1:0], lrclk};
    dat_n       = {dat_q[TOP-1:0], sdata};
    bclk_last_n = bclk_q[TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q      <= '0;
      lr_q        <= '0;
      dat_q       <= '0;
      bclk_last_q <= 1'b0;
    end else begin
      bclk_q      <= bclk_n;
      lr_q        <= lr_n;
      dat_q       <= dat_n;
      bclk_last_q <= bclk_last_n;
    end
  end

  assign evt   = fall_sel ? (bclk_last_q & ~bclk_q[TOP]) : (~bclk_last_q & bclk_q[TOP]);
  assign lr_s  = lr_q[TOP];
  assign dat_s = dat_q[TOP];
endmodule

// File: rtl/sarx_slot_track.sv
module sarx_slot_track
  import sarx_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             lr,
  input  fmt_e             fmt,
  output logic             slot_start,
  output logic             slot_left,
  output logic [IDX_W-1:0] idx,
  output logic             live
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic             lr_prev_q, lr_prev_n;
  logic             known_q, known_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             left_q, left_n;
  logic             active_q, active_n;
  logic             dsp_left_q, dsp_left_n;
  logic             left_lvl;

  always_comb begin
    left_lvl = (fmt != FMT_I2S);
    if (fmt == FMT_DSP) begin
      slot_start = evt & lr_prev_q & ~lr;
      slot_left  = slot_start ? dsp_left_q : left_q;
    end else begin
      slot_start = evt & known_q & (lr != lr_prev_q);
      slot_left  = (lr == left_lvl);
    end
    if (slot_start)          idx = '0;
    else if (idx_q == IDX_MAX) idx = IDX_MAX;
    else                     idx = idx_q + 1'b1;
    live = active_q | slot_start;
  end

  always_comb begin
    lr_prev_n  = lr_prev_q;
    known_n    = known_q;
    idx_n      = idx_q;
    left_n     = left_q;
    active_n   = active_q;
    dsp_left_n = dsp_left_q;
    if (evt) begin
      lr_prev_n = lr;
      known_n   = 1'b1;
      idx_n     = idx;
      left_n    = slot_left;
      if (slot_start) begin
        active_n = 1'b1;
        if (fmt == FMT_DSP) dsp_left_n = ~slot_left;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev_q  <= 1'b0;
      known_q    <= 1'b0;
      idx_q      <= '0;
      left_q     <= 1'b0;
      active_q   <= 1'b0;
      dsp_left_q <= 1'b1;
    end else begin
      lr_prev_q  <= lr_prev_n;
      known_q    <= known_n;
      idx_q      <= idx_n;
      left_q     <= left_n;
      active_q   <= active_n;
      dsp_left_q <= dsp_left_n;
    end
  end

  // R5: pulse-framed slots alternate between channels once running
  a_r5_dsp_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && fmt == FMT_DSP && active_q) |-> (slot_left != left_q));
endmodule

// File: rtl/sarx_window.sv
module sarx_window
  import sarx_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int IDX_W     = 6,
  parameter int RJ_REF    = 32,
  parameter int PACK_BITS = 16,
  parameter int LEN_STEP  = 4,
  localparam int POS_W    = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  fmt_e             fmt,
  input  logic [1:0]       rj_len,
  input  logic             pack_en,
  input  logic [IDX_W-1:0] idx,
  output logic             cap,
  output logic [POS_W-1:0] pos
);
  localparam int CW = IDX_W + 1;

  logic          pack_act;
  logic [CW-1:0] rj_bits, off, nbits, rel, idx_w;

  always_comb begin
    pack_act = pack_en & ((fmt == FMT_RJ) | (fmt == FMT_LJ));
    unique case (rj_len)
      2'b01:   rj_bits = CW'(WORD_W - LEN_STEP);
      2'b10:   rj_bits = CW'(WORD_W - 2 * LEN_STEP);
      default: rj_bits = CW'(WORD_W);
    endcase
    if (pack_act) begin
      off   = '0;
      nbits = CW'(PACK_BITS);
    end else if (fmt == FMT_RJ) begin
      off   = CW'(RJ_REF) - rj_bits;
      nbits = rj_bits;
    end else if (fmt == FMT_I2S) begin
      off   = CW'(1);
      nbits = CW'(WORD_W);
    end else begin
      off   = '0;
      nbits = CW'(WORD_W);
    end
    idx_w = {1'b0, idx};
    rel   = idx_w - off;
    cap   = live & (idx_w >= off) & (rel < nbits);
    pos   = rel[POS_W-1:0];
  end

  // R3: plain right-justified capture never begins before the 24-bit start
  a_r3_rj_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && fmt == FMT_RJ && !pack_en) |-> (idx >= IDX_W'(RJ_REF - WORD_W)));
  // R4: the transition bit is never part of an I2S word
  a_r4_i2s_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && fmt == FMT_I2S) |-> (idx != '0));
  // R6: no capture beyond the word width
  a_r6_no_excess: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> (rel < CW'(WORD_W)));
endmodule

// File: rtl/sarx_assembler.sv
module sarx_assembler #(
  parameter int WORD_W = 24,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              slot_start,
  input  logic              slot_left,
  input  logic              cap,
  input  logic [POS_W-1:0]  pos,
  input  logic              dat,
  output logic [WORD_W-1:0] left_smp,
  output logic [WORD_W-1:0] right_smp,
  output logic              frame_vld
);
  logic [WORD_W-1:0] wl_q, wl_n, wr_q, wr_n, lo_q, lo_n, ro_q, ro_n;
  logic              seen_l_q, seen_l_n, seen_r_q, seen_r_n, fv_q, fv_n;
  logic [POS_W-1:0]  bpos;

  always_comb begin
    wl_n     = wl_q;
    wr_n     = wr_q;
    lo_n     = lo_q;
    ro_n     = ro_q;
    seen_l_n = seen_l_q;
    seen_r_n = seen_r_q;
    fv_n     = 1'b0;
    bpos     = POS_W'(WORD_W - 1) - pos;
    if (evt) begin
      if (slot_start && slot_left && seen_l_q && seen_r_q) begin
        lo_n     = wl_q;
        ro_n     = wr_q;
        fv_n     = 1'b1;
        seen_r_n = 1'b0;
      end
      if (slot_start) begin
        if (slot_left) begin
          wl_n     = '0;
          seen_l_n = 1'b1;
        end else begin
          wr_n     = '0;
          seen_r_n = 1'b1;
        end
      end
      if (cap) begin
        if (slot_left) wl_n[bpos] = dat;
        else           wr_n[bpos] = dat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q     <= '0;
      wr_q     <= '0;
      lo_q     <= '0;
      ro_q     <= '0;
      seen_l_q <= 1'b0;
      seen_r_q <= 1'b0;
      fv_q     <= 1'b0;
    end else begin
      wl_q     <= wl_n;
      wr_q     <= wr_n;
      lo_q     <= lo_n;
      ro_q     <= ro_n;
      seen_l_q <= seen_l_n;
      seen_r_q <= seen_r_n;
      fv_q     <= fv_n;
    end
  end

  assign left_smp  = lo_q;
  assign right_smp = ro_q;
  assign frame_vld = fv_q;

  // R9: strobe lasts one cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);
  // R9: outputs move only together with the strobe
  a_r9_left_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left_smp) |-> frame_vld);
  a_r9_right_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_smp) |-> frame_vld);
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int IDX_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int RJ_REF      = 32,
  parameter int PACK_BITS   = 16,
  parameter int LEN_STEP    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              lrclk,
  input  logic              sdata,
  input  logic [1:0]        fmt_sel,
  input  logic [1:0]        rj_len,
  input  logic              pack_en,
  output logic [WORD_W-1:0] left_smp,
  output logic [WORD_W-1:0] right_smp,
  output logic              frame_vld
);
  localparam int POS_W = $clog2(WORD_W);

  fmt_e             fmt;
  logic             evt, lr_s, dat_s;
  logic             slot_start, slot_left, live, cap;
  logic [IDX_W-1:0] idx;
  logic [POS_W-1:0] pos;

  assign fmt = fmt_e'(fmt_sel);

  sarx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fall_sel(fmt == FMT_DSP), .evt(evt), .lr_s(lr_s), .dat_s(dat_s)
  );

  sarx_slot_track #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .evt(evt), .lr(lr_s), .fmt(fmt),
    .slot_start(slot_start), .slot_left(slot_left), .idx(idx), .live(live)
  );

  sarx_window #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .RJ_REF(RJ_REF),
    .PACK_BITS(PACK_BITS), .LEN_STEP(LEN_STEP)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .live(live), .fmt(fmt), .rj_len(rj_len),
    .pack_en(pack_en), .idx(idx), .cap(cap), .pos(pos)
  );

  sarx_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .evt(evt), .slot_start(slot_start),
    .slot_left(slot_left), .cap(cap), .pos(pos), .dat(dat_s),
    .left_smp(left_smp), .right_smp(right_smp), .frame_vld(frame_vld)
  );
endmodule

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bclk, lrclk, sdata, pack_en;
  logic [1:0]  fmt_sel, rj_len;
  logic [23:0] left_smp, right_smp;
  logic        frame_vld;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  bit dsp_m;
  int fmt_g, wl_g, pk_g;

  serial_audio_rx u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fmt_sel(fmt_sel), .rj_len(rj_len), .pack_en(pack_en),
    .left_smp(left_smp), .right_smp(right_smp), .frame_vld(frame_vld)
  );

  always @(posedge clk) if (rst_n && frame_vld) pulses <= pulses + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_word(input logic [31:0] w, input int wl);
    logic [31:0] t;
    if (wl >= 24) t = w >> (wl - 24);
    else          t = w << (24 - wl);
    return t[23:0];
  endfunction

  function automatic logic bitval(input logic [31:0] w, input int i, input int h);
    if (pk_g != 0 || fmt_g == 2 || fmt_g == 3) return (i < wl_g) ? w[wl_g-1-i] : 1'b0;
    if (fmt_g == 1) return (i >= 1 && i <= wl_g) ? w[wl_g-i] : 1'b0;
    return (i >= h - wl_g) ? w[h-1-i] : 1'b0;
  endfunction

  // One bit clock: data settles, active edge, then four sampled clk cycles (R10)
  task automatic tick(input logic lr, input logic d, input bit do_chk,
                      input logic [23:0] el, input logic [23:0] er, input string req);
    bclk = dsp_m; lrclk = lr; sdata = d;
    repeat (4) @(negedge clk);
    bclk = ~dsp_m;
    @(negedge clk);
    if (do_chk) chk(frame_vld == 1'b0, "R10 early", {31'd0, frame_vld}, 32'd0);
    @(negedge clk);
    if (do_chk) chk(frame_vld == 1'b0, "R10 early", {31'd0, frame_vld}, 32'd0);
    @(negedge clk);
    if (do_chk) begin
      chk(frame_vld == 1'b1, "R10 due", {31'd0, frame_vld}, 32'd1);
      chk(left_smp == el, {req, " left"}, {8'd0, left_smp}, {8'd0, el});
      chk(right_smp == er, {req, " right"}, {8'd0, right_smp}, {8'd0, er});
    end
    @(negedge clk);
    if (do_chk) chk(frame_vld == 1'b0, "R9 one cycle", {31'd0, frame_vld}, 32'd0);
  endtask

  task automatic send_slot(input bit is_left, input logic [31:0] w, input bit do_chk,
                           input logic [23:0] el, input logic [23:0] er, input string req);
    int  h;
    logic lr;
    h = (pk_g != 0) ? 16 : 32;
    if (fmt_g == 3) begin
      tick(1'b1, 1'b0, 1'b0, el, er, req);
      for (int i = 0; i < 32; i++) tick(1'b0, bitval(w, i, 32), do_chk && i == 0, el, er, req);
    end else begin
      lr = is_left ? (fmt_g != 1) : (fmt_g == 1);
      for (int i = 0; i < h; i++) tick(lr, bitval(w, i, h), do_chk && i == 0, el, er, req);
    end
  endtask

  function automatic logic [31:0] gen(input int f, input int side, input int wl);
    logic [31:0] w;
    if (f == 0)      w = 32'hFFFF_FFFF;
    else if (f == 1) w = side ? 32'd1 : (32'd1 << (wl - 1));
    else             w = (32'h9E37_79B9 * (f * 2 + side + fmt_g * 7 + wl)) ^ 32'h5A5A_1234;
    if (wl < 32) w = w & ((32'd1 << wl) - 32'd1);
    return w;
  endfunction

  task automatic run_cfg(input int fm, input int len, input int pk, input int wl, input string req);
    logic [23:0] pl, pr;
    logic [31:0] wl_w, wr_w;
    int base;
    rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
    fmt_sel = 2'(fm); rj_len = 2'(len); pack_en = pk[0];
    fmt_g = fm; wl_g = wl;
    pk_g = (pk != 0 && (fm == 0 || fm == 2)) ? 1 : 0;
    dsp_m = (fm == 3);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(left_smp == 24'd0 && right_smp == 24'd0, "R1 samples", {8'd0, left_smp}, 32'd0);
    chk(frame_vld == 1'b0, "R1 strobe", {31'd0, frame_vld}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    base = pulses;
    pl = '0; pr = '0;
    for (int k = 0; k < 2; k++)
      tick((fm == 1) ? 1'b1 : 1'b0, 1'b0, 1'b0, pl, pr, req);
    chk(left_smp == 24'd0 && frame_vld == 1'b0, "R1 idle", {8'd0, left_smp}, 32'd0);
    for (int f = 0; f < 4; f++) begin
      wl_w = gen(f, 0, wl);
      wr_w = gen(f, 1, wl);
      send_slot(1'b1, wl_w, f > 0, pl, pr, req);
      send_slot(1'b0, wr_w, 1'b0, pl, pr, req);
      pl = expect_word(wl_w, wl);
      pr = expect_word(wr_w, wl);
    end
    send_slot(1'b1, 32'd0, 1'b1, pl, pr, req);
    @(negedge clk);
    chk(pulses - base == 4, "R9 strobe count", 32'(pulses - base), 32'd4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL R10 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    run_cfg(0, 0, 0, 24, "R2/R3 rj24");
    run_cfg(0, 1, 0, 20, "R7 rj20");
    run_cfg(0, 2, 0, 16, "R7 rj16");
    run_cfg(0, 3, 0, 24, "R3 rj code11");
    run_cfg(2, 0, 0, 24, "R2/R4 lj24");
    run_cfg(2, 0, 0, 28, "R6 lj28");
    run_cfg(2, 0, 0, 16, "R7 lj16");
    run_cfg(1, 0, 0, 24, "R2/R4 i2s24");
    run_cfg(1, 0, 0, 28, "R6 i2s28");
    run_cfg(3, 0, 0, 24, "R5 dsp24");
    run_cfg(3, 0, 0, 28, "R6 dsp28");
    run_cfg(0, 0, 1, 16, "R8 packed rj");
    run_cfg(2, 0, 1, 16, "R8 packed lj");
    run_cfg(1, 0, 1, 24, "R8 pack ignored i2s");
    run_cfg(3, 0, 1, 24, "R8 pack ignored dsp");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule